// File: doc/BRIEF.md
# Receive Frame Length Guard

This block sits in a byte-wide receive path behind the MAC. It counts the bytes of every frame and applies a length policy with three tiers. A hard receive watchdog ends a frame after 2048 bytes. With the watchdog turned off, standard frames and jumbo frames each have their own giant-frame threshold. A ceiling of 10240 bytes keeps the byte counter bounded. The block can also discard whole frames that begin while the local transmitter is driving the line.

Bytes enter and leave on valid/ready streams, with start-of-frame and end-of-frame markers on each beat. Input and output run in lock step, with no storage between them. A beat that is forwarded moves only when the downstream sink is ready, so back-pressure reaches the source unchanged. A beat the guard throws away is consumed at once, whatever the sink does. A source must hold a beat stable while valid is high and ready is low. Each frame that is not discarded produces a 16-bit status word, shown with a one-cycle pulse. The configuration pins are plain levels. The block samples them on the first beat of each frame.

Top module: `frame_len_guard`

## Requirements
- R1: With `cfg_wd_off`=0, at most 2048 bytes of a frame are forwarded. The 2048th forwarded byte carries `out_eof`=1, and the remaining input bytes are consumed but not forwarded. Such a frame has the truncated bit set in its status. `trunc_flag` goes high once an over-limit byte has been consumed and stays high until the next frame starts.
- R2: With `cfg_wd_off`=1, frames longer than 2048 bytes are forwarded in full, up to the ceiling in R5.
- R3: With `cfg_wd_off`=1 and `cfg_jumbo_en`=1, a frame of up to 9018 bytes is forwarded whole, and its status has giant=0 and truncated=0.
- R4: With `cfg_wd_off`=1 and `cfg_jumbo_en`=1, a frame of 9019 to 10240 bytes is forwarded whole, and its status has giant=1 and truncated=0.
- R5: When the watchdog is off, a frame longer than 10240 bytes is cut after byte 10240. The byte count is 10240, giant=1 and truncated=1.
- R6: With `cfg_jumbo_en`=0, a frame that exceeds 1518 bytes and is not cut by the watchdog has giant=1. A frame of 1518 bytes or fewer has giant=0. A frame cut by the watchdog has giant=0.
- R7: With `cfg_jumbo_en`=1 and `cfg_wd_off`=0, the 2048-byte cutoff of R1 still applies.
- R8: With `cfg_own_drop`=1, a frame whose first beat arrives while `tx_active`=1 is discarded entirely. None of its bytes are forwarded, no status pulse is produced, and its input beats are accepted whatever `out_ready` is. With `cfg_own_drop`=0, or with `tx_active`=0, the frame is received normally.
- R9: `stat_word` has giant in bit 15, truncated in bit 14 and the forwarded byte count in bits 13:0. `stat_valid` is high for exactly the cycle that follows the clock edge on which the frame's last input beat was accepted.
- R10: The configuration pins are sampled on the first beat of a frame. A change made in mid-frame takes effect from the next frame.
- R11: While a beat is being forwarded, `in_ready` equals `out_ready`. No forwarded byte is lost, duplicated or reordered under back-pressure.
- R12: A synchronous active-high `rst` clears the counter, the status outputs and `trunc_flag`, and abandons any frame in progress. Bytes that arrive outside a frame (no start marker seen) are consumed and dropped, and they produce no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream sink ready |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | Forwarded byte starts a frame |
| out_eof | output | 1 | Forwarded byte ends a frame (also forced at a cut) |
| tx_active | input | 1 | Local transmitter is active |
| cfg_wd_off | input | 1 | 1 turns off the 2048-byte watchdog |
| cfg_jumbo_en | input | 1 | 1 selects the 9018-byte giant threshold |
| cfg_own_drop | input | 1 | 1 discards frames that begin while transmitting |
| stat_valid | output | 1 | One-cycle status strobe |
| stat_word | output | 16 | {giant, truncated, count[13:0]} |
| trunc_flag | output | 1 | Current or last frame lost bytes to a length cut |

## Verification
Two pairs of functions meet on a single beat. The first pair is the end of one frame and the start of the next: a frame is followed directly by another frame under a different configuration, and the status word is checked against the policy of the frame that ended, not the one starting. The second pair is the forced end marker at a length cut and downstream back-pressure. A cut frame is sent while `out_ready` toggles, and the test checks that the forced `out_eof` lands on byte 2048 or 10240, that the forwarded data stays in sequence, and that `in_ready` is never high while a forwarded beat is stalled.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int CNT_W = 14;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic wd_off;
    logic jumbo_en;
    logic own_drop;
  } cfg_t;

  typedef struct packed {
    logic giant;
    logic trunc;
    cnt_t count;
  } stat_t;
endpackage

// File: rtl/flg_cfg_hold.sv
module flg_cfg_hold
  import flg_pkg::*;
#(
  parameter int WD_LIMIT  = 2048,
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 9018,
  parameter int HARD_MAX  = 10240
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_beat,   // first beat present (not yet accepted)
  input  logic start,      // first beat accepted
  input  cfg_t live,
  output cnt_t cap,
  output cnt_t thr,
  output logic wd_act
);
  localparam cnt_t WD_C    = cnt_t'(WD_LIMIT);
  localparam cnt_t HARD_C  = cnt_t'(HARD_MAX);
  localparam cnt_t STD_C   = cnt_t'(STD_MAX);
  localparam cnt_t JUMBO_C = cnt_t'(JUMBO_MAX);

  cfg_t held_q;
  cfg_t eff;

  always_ff @(posedge clk) begin
    if (rst)        held_q <= '0;
    else if (start) held_q <= live;
  end

  always_comb begin
    eff    = sof_beat ? live : held_q;
    wd_act = ~eff.wd_off;
    cap    = wd_act ? WD_C : HARD_C;
    thr    = eff.jumbo_en ? JUMBO_C : STD_C;
  end

  // R10: the held copy only moves on an accepted first beat
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(held_q));
endmodule

// File: rtl/flg_track.sv
module flg_track
  import flg_pkg::*;
#(
  parameter int HARD_MAX = 10240
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sof,
  input  logic in_eof,
  input  logic out_ready,
  input  logic own_now,
  input  logic tx_active,
  input  cnt_t cap,
  output logic in_ready,
  output logic out_valid,
  output logic out_eof,
  output logic fin,
  output logic trunc_now,
  output logic cut_flag,
  output cnt_t new_cnt
);
  logic in_frame_q, drop_q, cut_q;
  cnt_t cnt_q;
  cnt_t base;
  logic cur_drop, room, keep, over, fire;

  always_comb begin
    base      = in_sof ? '0 : cnt_q;
    cur_drop  = in_sof ? (own_now & tx_active) : (drop_q | ~in_frame_q);
    room      = base < cap;
    keep      = ~cur_drop & room;
    over      = ~cur_drop & ~room;
    out_valid = in_valid & keep;
    in_ready  = keep ? out_ready : 1'b1;
    fire      = in_valid & in_ready;
    new_cnt   = keep ? base + cnt_t'(1) : base;
    out_eof   = in_eof | (keep & (new_cnt == cap));
    fin       = fire & in_eof & ~cur_drop;
    trunc_now = over | (cut_q & ~in_sof);
  end

  assign cut_flag = cut_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      cut_q      <= 1'b0;
      cnt_q      <= '0;
    end else if (fire) begin
      cnt_q      <= new_cnt;
      drop_q     <= cur_drop;
      cut_q      <= trunc_now;
      in_frame_q <= (in_sof | in_frame_q) & ~in_eof;
    end
  end

  // R5: the running count never passes the ceiling
  p_cnt_cap_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cnt_t'(HARD_MAX));

  // R12: a cleared frame state forwards nothing until a start marker
  p_stray_r12: assert property (@(posedge clk) disable iff (rst)
    (!in_frame_q && !in_sof) |-> !out_valid);
endmodule

// File: rtl/flg_status.sv
module flg_status
  import flg_pkg::*;
#(
  parameter int WD_LIMIT = 2048,
  parameter int STD_MAX  = 1518,
  parameter int HARD_MAX = 10240
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fin,
  input  cnt_t  new_cnt,
  input  logic  trunc_now,
  input  cnt_t  thr,
  input  logic  wd_act,
  output logic  stat_valid,
  output stat_t stat
);
  logic giant_now;

  assign giant_now = (new_cnt > thr) & ~(trunc_now & wd_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat       <= '0;
    end else begin
      stat_valid <= fin;
      if (fin) stat <= '{giant: giant_now, trunc: trunc_now, count: new_cnt};
    end
  end

  // R1/R5: a truncated frame stops exactly at one of the two cut points
  p_trunc_len_r1: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat.trunc) |->
      (stat.count == cnt_t'(WD_LIMIT) || stat.count == cnt_t'(HARD_MAX)));

  // R6: nothing at or below the standard size is ever giant
  p_giant_thr_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat.count <= cnt_t'(STD_MAX)) |-> !stat.giant);
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard
  import flg_pkg::*;
#(
  parameter int WD_LIMIT  = 2048,
  parameter int STD_MAX   = 1518,
  parameter int JUMBO_MAX = 9018,
  parameter int HARD_MAX  = 10240
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  input  logic        tx_active,
  input  logic        cfg_wd_off,
  input  logic        cfg_jumbo_en,
  input  logic        cfg_own_drop,
  output logic        stat_valid,
  output logic [15:0] stat_word,
  output logic        trunc_flag
);
  cfg_t  live;
  cnt_t  cap, thr, new_cnt;
  logic  wd_act, fin, trunc_now, sof_beat, start;
  stat_t stat;

  assign live     = '{wd_off: cfg_wd_off, jumbo_en: cfg_jumbo_en, own_drop: cfg_own_drop};
  assign sof_beat = in_valid & in_sof;
  assign start    = sof_beat & in_ready;
  assign out_data = in_data;
  assign out_sof  = in_sof;
  assign stat_word = stat;

  flg_cfg_hold #(
    .WD_LIMIT(WD_LIMIT), .STD_MAX(STD_MAX),
    .JUMBO_MAX(JUMBO_MAX), .HARD_MAX(HARD_MAX)
  ) u_cfg (
    .clk(clk), .rst(rst), .sof_beat(sof_beat), .start(start),
    .live(live), .cap(cap), .thr(thr), .wd_act(wd_act)
  );

  flg_track #(.HARD_MAX(HARD_MAX)) u_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .out_ready(out_ready), .own_now(cfg_own_drop),
    .tx_active(tx_active), .cap(cap), .in_ready(in_ready),
    .out_valid(out_valid), .out_eof(out_eof), .fin(fin),
    .trunc_now(trunc_now), .cut_flag(trunc_flag), .new_cnt(new_cnt)
  );

  flg_status #(
    .WD_LIMIT(WD_LIMIT), .STD_MAX(STD_MAX), .HARD_MAX(HARD_MAX)
  ) u_st (
    .clk(clk), .rst(rst), .fin(fin), .new_cnt(new_cnt),
    .trunc_now(trunc_now), .thr(thr), .wd_act(wd_act),
    .stat_valid(stat_valid), .stat(stat)
  );

  // R11: a stalled forwarded beat never reports acceptance upstream
  p_bp_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_frame_len_guard.sv
`timescale 1ns/1ps
module sim_frame_len_guard;
  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic tx_active = 0, cfg_wd_off = 0, cfg_jumbo_en = 0, cfg_own_drop = 0;
  logic in_ready, out_valid, out_sof, out_eof, stat_valid, trunc_flag;
  logic [7:0] out_data;
  logic [15:0] stat_word;

  frame_len_guard u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .tx_active(tx_active),
    .cfg_wd_off(cfg_wd_off), .cfg_jumbo_en(cfg_jumbo_en),
    .cfg_own_drop(cfg_own_drop), .stat_valid(stat_valid),
    .stat_word(stat_word), .trunc_flag(trunc_flag)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int fwd_n, eof_n, eof_pos, stat_n, data_err, stalls, bp_viol;
  int eof_cyc, stat_cyc, rdy_mode = 0, bp_cnt = 0;
  logic [15:0] last_stat;

  typedef struct packed {
    int len; bit wd; bit jm; bit own; bit tx;
    int fwd; bit g; bit t; bit st;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{64,    0,0,0,0, 64,    0,0,1},  // R9 short frame
    '{1518,  0,0,0,0, 1518,  0,0,1},  // R6 at standard size
    '{1519,  0,0,0,0, 1519,  1,0,1},  // R6 one over
    '{2048,  0,0,0,0, 2048,  1,0,1},  // R1 exactly at cutoff
    '{2049,  0,0,0,0, 2048,  0,1,1},  // R1 one over cutoff
    '{3000,  1,0,0,0, 3000,  1,0,1},  // R2 watchdog off
    '{3000,  0,1,0,0, 2048,  0,1,1},  // R7 jumbo but watchdog on
    '{9018,  1,1,0,0, 9018,  0,0,1},  // R3 jumbo edge
    '{9019,  1,1,0,0, 9019,  1,0,1},  // R4 first giant jumbo
    '{10240, 1,1,0,0, 10240, 1,0,1},  // R4 at ceiling
    '{10300, 1,1,0,0, 10240, 1,1,1},  // R5 over ceiling
    '{100,   0,0,1,1, 0,     0,0,0},  // R8 dropped
    '{100,   0,0,0,1, 100,   0,0,1},  // R8 own-drop off
    '{100,   0,0,1,0, 100,   0,0,1}   // R8 not transmitting
  };

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (bp_cnt % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && !out_ready) begin
        stalls++;
        if (in_ready) bp_viol++;
      end
      if (out_valid && out_ready) begin
        if (out_data != fwd_n[7:0]) data_err++;
        if (out_eof) begin eof_n++; eof_pos = fwd_n + 1; end
        fwd_n++;
      end
      if (stat_valid) begin stat_n++; last_stat = stat_word; stat_cyc = cyc; end
    end
  end

  task automatic clr();
    fwd_n = 0; eof_n = 0; eof_pos = 0; stat_n = 0; data_err = 0;
    stalls = 0; bp_viol = 0; eof_cyc = -1; stat_cyc = -2; last_stat = 0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int len, input bit wd, input bit jm, input bit own,
                      input bit tx, input int flip_at, input bit no_eof);
    cfg_wd_off = wd; cfg_jumbo_en = jm; cfg_own_drop = own; tx_active = tx;
    for (int i = 0; i < len; i++) begin
      bit taken;
      if (i == flip_at) cfg_wd_off = ~wd;
      in_valid = 1; in_data = i[7:0]; in_sof = (i == 0);
      in_eof = (i == len - 1) && !no_eof;
      forever begin
        @(negedge clk); taken = in_ready;
        @(posedge clk); #1;
        if (taken) break;
      end
      if (in_eof) eof_cyc = cyc;
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "stat_valid after reset", int'(stat_valid), 0);
    chk("R12", "stat_word after reset", int'(stat_word), 0);
    chk("R12", "trunc_flag after reset", int'(trunc_flag), 0);
    chk("R12", "out_valid after reset", int'(out_valid), 0);
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("vec%0d", v);
      clr();
      send(VECS[v].len, VECS[v].wd, VECS[v].jm, VECS[v].own, VECS[v].tx, -1, 0);
      chk(rq, "forwarded bytes", fwd_n, VECS[v].fwd);
      chk(rq, "data order", data_err, 0);
      chk(rq, "end markers", eof_n, (VECS[v].fwd > 0) ? 1 : 0);
      if (VECS[v].fwd > 0) chk(rq, "end marker position", eof_pos, VECS[v].fwd);
      chk(rq, "status pulses", stat_n, int'(VECS[v].st));
      if (VECS[v].st) begin
        chk(rq, "R9 count field", int'(last_stat[13:0]), VECS[v].fwd);
        chk(rq, "giant bit", int'(last_stat[15]), int'(VECS[v].g));
        chk(rq, "truncated bit", int'(last_stat[14]), int'(VECS[v].t));
        chk(rq, "R9 pulse timing", stat_cyc, eof_cyc);
      end
      chk(rq, "R1 trunc_flag", int'(trunc_flag), int'(VECS[v].t));
    end

    // R10: watchdog turned on mid-frame does not cut this frame
    clr();
    send(3000, 1, 0, 0, 0, 10, 0);
    chk("R10", "mid-frame change ignored", fwd_n, 3000);
    chk("R10", "truncated bit", int'(stat_word[14]), 0);
    clr();
    send(3000, 0, 0, 0, 0, -1, 0);
    chk("R10", "next frame uses new setting", fwd_n, 2048);

    // R11 with R1: cut frame under back-pressure
    clr(); rdy_mode = 1;
    send(2100, 0, 0, 0, 0, -1, 0);
    rdy_mode = 0;
    chk("R11", "stalls seen", int'(stalls > 0), 1);
    chk("R11", "ready while stalled", bp_viol, 0);
    chk("R11", "data order", data_err, 0);
    chk("R1", "cut under back-pressure", fwd_n, 2048);
    chk("R1", "forced end position", eof_pos, 2048);

    // R8: discarded frame drains with sink stalled
    clr(); rdy_mode = 2;
    send(50, 0, 0, 1, 1, -1, 0);
    rdy_mode = 0;
    chk("R8", "drop drains with sink stalled", fwd_n, 0);
    chk("R8", "no status for dropped frame", stat_n, 0);

    // R9: back-to-back one-byte frames give two pulses
    clr();
    send(1, 0, 0, 0, 0, -1, 0);
    send(1, 0, 0, 0, 0, -1, 0);
    chk("R9", "one-byte frames status", stat_n, 2);
    chk("R9", "one-byte count", int'(last_stat[13:0]), 1);

    // R12: reset mid-frame, then stray bytes without a start marker
    clr();
    send(40, 0, 0, 0, 0, -1, 1);
    rst = 1; repeat (2) @(posedge clk); #1 rst = 0;
    chk("R12", "status after mid-frame reset", int'(stat_word), 0);
    clr();
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_sof = 0; in_eof = (i == 4); in_data = 8'hA5;
      @(posedge clk); #1;
    end
    in_valid = 0; in_eof = 0;
    repeat (3) @(posedge clk); #1;
    chk("R12", "stray bytes forwarded", fwd_n, 0);
    chk("R12", "stray bytes status", stat_n, 0);
    clr();
    send(64, 0, 0, 0, 0, -1, 0);
    chk("R12", "frame after reset", int'(stat_word), 64);

    summary();
    $finish;
  end
endmodule